// File: doc/BRIEF.md
# Predicated Contiguous Vector Load Sequencer

This block carries out one load of a full vector register from consecutive 64-bit memory words, under control of a lane mask. It takes a 32-bit instruction word and decodes it. In the same cycle it reads a base value and a running index from the scalar register file, or it takes the base from the stack pointer. It also reads one predicate register. It then visits the lanes in ascending order. For each lane whose predicate bit is set, it issues one read to memory. For each lane whose bit is clear, it writes zero into that lane and does not touch memory.

Addresses follow the rule base + (index + lane) × 8. The index is advanced inside the block for every lane, including lanes that are masked off. The scalar register that supplied the index is never written back. When every lane is finished, the complete vector goes to the destination register in one write strobe.

An encoding outside the accepted pattern raises an undefined-instruction pulse. A misaligned stack-pointer base raises an alignment-error pulse. In both cases no memory access and no write-back take place.

Top module: `vec_ld_seq`

## Requirements
- R1: An instruction is legal only when bits 31..21 equal 11'b10100101111 and bits 15..13 equal 3'b010. Any other word gives a one-cycle `undef_o` pulse, with no memory request and no write-back.
- R2: A word that matches the pattern but has the index-register field (bits 20..16) equal to 31 is also undefined. It gives `undef_o`, with no memory request and no write-back.
- R3: The address for lane e is (base + ((index + e) << 3)) mod 2^64. Requests go out in ascending lane order, with at most one outstanding at a time.
- R4: A lane whose predicate bit is 0 issues no memory request and reads as zero in the written vector. The running index still advances for that lane. The predicate bit for lane e is bit 8·e of the selected predicate register.
- R5: An active lane receives the response data unchanged: 64 bits, with no extension.
- R6: The field in bits 9..5 selects the base. Value 31 takes `sp_data`; any other value takes the general register with that number. Bits 20..16 select the index register, bits 12..10 select the predicate register (0..7), and bits 4..0 select the destination.
- R7: With a stack-pointer base whose low 4 bits are not all zero, the block gives a one-cycle `align_err_o` pulse, with no memory request and no write-back. A general-register base has no alignment check.
- R8: Completion is a single one-cycle `wb_valid` pulse. It carries `wb_idx` equal to the destination field and the whole vector, with lane e in bits [64e+63:64e]. At most one of `wb_valid`, `undef_o` and `align_err_o` is high in any cycle.
- R9: `in_ready` is high only while idle. After a legal instruction is accepted it drops in the next cycle and stays low until the write-back has occurred. After an undefined or misaligned instruction it stays high.
- R10: A request whose `mreq_ready` is low keeps `mreq_valid` high and keeps `mreq_addr` unchanged in the next cycle.
- R11: When every predicate bit is clear, the block completes with an all-zero vector and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when in_valid is high |
| in_insn | input | 32 | Instruction word |
| gpr_rn_idx | output | 5 | Base register number (read port A) |
| gpr_rn_data | input | 64 | Base register value |
| gpr_rm_idx | output | 5 | Index register number (read port B) |
| gpr_rm_data | input | 64 | Index register value |
| sp_data | input | 64 | Stack pointer value |
| pred_idx | output | 3 | Predicate register number |
| pred_data | input | NUM_ELEM*8 | Predicate register contents |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_addr | output | 64 | Byte address of request |
| mresp_valid | input | 1 | Read data valid pulse |
| mresp_data | input | 64 | Read data |
| wb_valid | output | 1 | Vector write-back strobe (done) |
| wb_idx | output | 5 | Destination vector register number |
| wb_data | output | NUM_ELEM*64 | Vector to write |
| undef_o | output | 1 | Undefined-instruction pulse |
| align_err_o | output | 1 | Stack-pointer misalignment pulse |

## Verification
The running index and the lane counter are the internal state that matters. Either one being wrong shows up at once on `mreq_addr`: the next request after the fault carries an address that differs from base + (index + lane) × 8. A lost or duplicated lane write shows only at the single `wb_valid` strobe, as one wrong 64-bit slice of `wb_data`. A wrong mask capture appears as an extra or missing request at the first affected lane. A decode error appears one cycle after acceptance, either as a missing `undef_o` pulse or as a spurious one.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int PG_IDX_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LANE,
        ST_WAIT,
        ST_WB
    } vls_state_e;
endpackage

// File: rtl/vls_decode.sv
`timescale 1ns/1ps
module vls_decode
    import vls_pkg::*;
(
    input  logic [INSN_W-1:0]    insn,
    output logic                 pattern_ok,
    output logic                 idx_is_zr,
    output logic                 base_is_sp,
    output logic [REG_IDX_W-1:0] idx_reg,
    output logic [REG_IDX_W-1:0] base_reg,
    output logic [PG_IDX_W-1:0]  pg_reg,
    output logic [REG_IDX_W-1:0] dst_reg
);
    localparam logic [10:0] OPC_HI  = 11'b10100101111;
    localparam logic [2:0]  OPC_MID = 3'b010;

    always_comb begin
        idx_reg    = insn[20:16];
        pg_reg     = insn[12:10];
        base_reg   = insn[9:5];
        dst_reg    = insn[4:0];
        pattern_ok = (insn[31:21] == OPC_HI) && (insn[15:13] == OPC_MID);
        idx_is_zr  = (idx_reg == '1);
        base_is_sp = (base_reg == '1);
    end
endmodule

// File: rtl/vls_agen.sv
`timescale 1ns/1ps
module vls_agen #(
    parameter int XLEN       = 64,
    parameter int ELEM_BYTES = 8
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] addr
);
    localparam int SHIFT = $clog2(ELEM_BYTES);

    always_comb begin
        addr = base + (offset << SHIFT);
    end
endmodule

// File: rtl/vls_lane_buf.sv
`timescale 1ns/1ps
module vls_lane_buf #(
    parameter int NUM_ELEM = 4,
    parameter int ELEM_W   = 64,
    localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_lane,
    input  logic [ELEM_W-1:0]          wr_data,
    output logic [NUM_ELEM*ELEM_W-1:0] vec
);
    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
        logic [ELEM_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (wr_en && (wr_lane == IDX_W'(i))) begin
                lane_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign vec[i*ELEM_W +: ELEM_W] = lane_q;
    end
endmodule

// File: rtl/vec_ld_seq.sv
`timescale 1ns/1ps
module vec_ld_seq
    import vls_pkg::*;
#(
    parameter int NUM_ELEM      = 4,
    parameter int ELEM_W        = 64,
    parameter int XLEN          = 64,
    parameter int PRED_GRP      = 8,
    parameter int SP_ALIGN_BITS = 4,
    localparam int IDX_W        = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int PRED_W       = NUM_ELEM * PRED_GRP,
    localparam int VEC_W        = NUM_ELEM * ELEM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [INSN_W-1:0]    in_insn,
    output logic [REG_IDX_W-1:0] gpr_rn_idx,
    input  logic [XLEN-1:0]      gpr_rn_data,
    output logic [REG_IDX_W-1:0] gpr_rm_idx,
    input  logic [XLEN-1:0]      gpr_rm_data,
    input  logic [XLEN-1:0]      sp_data,
    output logic [PG_IDX_W-1:0]  pred_idx,
    input  logic [PRED_W-1:0]    pred_data,
    output logic                 mreq_valid,
    input  logic                 mreq_ready,
    output logic [XLEN-1:0]      mreq_addr,
    input  logic                 mresp_valid,
    input  logic [ELEM_W-1:0]    mresp_data,
    output logic                 wb_valid,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [VEC_W-1:0]     wb_data,
    output logic                 undef_o,
    output logic                 align_err_o
);
    typedef struct packed {
        vls_state_e           st;
        logic [IDX_W-1:0]     elem;
        logic [XLEN-1:0]      offset;
        logic [XLEN-1:0]      base;
        logic [NUM_ELEM-1:0]  mask;
        logic [REG_IDX_W-1:0] dst;
        logic                 undef;
        logic                 aerr;
    } seq_t;

    seq_t seq_d, seq_q;

    // decode of the offered word
    logic                 dec_ok, dec_zr, dec_sp;
    logic [REG_IDX_W-1:0] dec_dst;

    vls_decode u_dec (
        .insn       (in_insn),
        .pattern_ok (dec_ok),
        .idx_is_zr  (dec_zr),
        .base_is_sp (dec_sp),
        .idx_reg    (gpr_rm_idx),
        .base_reg   (gpr_rn_idx),
        .pg_reg     (pred_idx),
        .dst_reg    (dec_dst)
    );

    // one predicate bit per lane: lowest bit of its group
    logic [NUM_ELEM-1:0] pred_mask;
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_mask
        assign pred_mask[e] = pred_data[e*PRED_GRP];
    end
    logic unused_pred_bits;
    assign unused_pred_bits = ^pred_data;

    vls_agen #(.XLEN(XLEN), .ELEM_BYTES(ELEM_W/8)) u_agen (
        .base   (seq_q.base),
        .offset (seq_q.offset),
        .addr   (mreq_addr)
    );

    logic              lb_we;
    logic [ELEM_W-1:0] lb_data;

    vls_lane_buf #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lb_we),
        .wr_lane (seq_q.elem),
        .wr_data (lb_data),
        .vec     (wb_data)
    );

    logic lane_done;
    logic sp_misaligned;
    assign sp_misaligned = |sp_data[SP_ALIGN_BITS-1:0];

    always_comb begin
        seq_d      = seq_q;
        seq_d.undef = 1'b0;
        seq_d.aerr  = 1'b0;
        lane_done  = 1'b0;
        lb_we      = 1'b0;
        lb_data    = '0;
        mreq_valid = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!dec_ok || dec_zr) begin
                        seq_d.undef = 1'b1;
                    end else if (dec_sp && sp_misaligned) begin
                        seq_d.aerr = 1'b1;
                    end else begin
                        seq_d.st     = ST_LANE;
                        seq_d.elem   = '0;
                        seq_d.offset = gpr_rm_data;
                        seq_d.base   = dec_sp ? sp_data : gpr_rn_data;
                        seq_d.mask   = pred_mask;
                        seq_d.dst    = dec_dst;
                    end
                end
            end
            ST_LANE: begin
                if (seq_q.mask[seq_q.elem]) begin
                    mreq_valid = 1'b1;
                    if (mreq_ready) seq_d.st = ST_WAIT;
                end else begin
                    lb_we     = 1'b1;
                    lane_done = 1'b1;
                end
            end
            ST_WAIT: begin
                if (mresp_valid) begin
                    lb_we     = 1'b1;
                    lb_data   = mresp_data;
                    lane_done = 1'b1;
                end
            end
            ST_WB: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (lane_done) begin
            seq_d.offset = seq_q.offset + XLEN'(1);
            if (seq_q.elem == IDX_W'(NUM_ELEM - 1)) begin
                seq_d.st = ST_WB;
            end else begin
                seq_d.elem = seq_q.elem + IDX_W'(1);
                seq_d.st   = ST_LANE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_ready    = (seq_q.st == ST_IDLE);
    assign wb_valid    = (seq_q.st == ST_WB);
    assign wb_idx      = seq_q.dst;
    assign undef_o     = seq_q.undef;
    assign align_err_o = seq_q.aerr;

    // R10: a stalled request holds
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

    // R8: outcomes are exclusive, and write-back is a single pulse
    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, undef_o, align_err_o}));
    p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R1, R7: a rejected instruction never reaches memory
    p_no_req_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || align_err_o) |-> !mreq_valid);

    // R9: a legal accept leaves idle, a rejected one stays idle
    p_accept_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (in_ready == (undef_o || align_err_o)));

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mreq_valid);
endmodule

// File: tb/vec_ld_seq_tb_top.sv
`timescale 1ns/1ps
module vec_ld_seq_tb_top;
    localparam int NE = 4;
    localparam int VW = NE * 64;
    localparam int PW = NE * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_insn = '0;
    logic [4:0]    gpr_rn_idx, gpr_rm_idx;
    logic [63:0]   gpr_rn_data, gpr_rm_data;
    logic [63:0]   sp_data = '0;
    logic [2:0]    pred_idx;
    logic [PW-1:0] pred_data;
    logic          mreq_valid;
    logic          mreq_ready = 1'b0;
    logic [63:0]   mreq_addr;
    logic          mresp_valid = 1'b0;
    logic [63:0]   mresp_data = '0;
    logic          wb_valid;
    logic [4:0]    wb_idx;
    logic [VW-1:0] wb_data;
    logic          undef_o, align_err_o;

    logic [63:0]   gpr [0:31];
    logic [PW-1:0] preg [0:7];

    assign gpr_rn_data = gpr[gpr_rn_idx];
    assign gpr_rm_data = gpr[gpr_rm_idx];
    assign pred_data   = preg[pred_idx];

    always #2.5 clk = ~clk;

    vec_ld_seq dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .gpr_rn_idx(gpr_rn_idx), .gpr_rn_data(gpr_rn_data),
        .gpr_rm_idx(gpr_rm_idx), .gpr_rm_data(gpr_rm_data), .sp_data(sp_data),
        .pred_idx(pred_idx), .pred_data(pred_data), .mreq_valid(mreq_valid),
        .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .mresp_valid(mresp_valid),
        .mresp_data(mresp_data), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .undef_o(undef_o), .align_err_o(align_err_o)
    );

    int checks = 0;
    int failures = 0;

    int          exp_n;
    logic [63:0] exp_addr [NE];
    int          req_seen;
    int          pending = -1;
    logic [63:0] held_addr;

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_fn(input logic [63:0] a);
        return (a * 64'h9E3779B97F4A7C15) ^ {a[31:0], a[63:32]};
    endfunction

    function automatic logic [31:0] mk_insn(input logic [4:0] rm, input logic [2:0] pg,
                                            input logic [4:0] rn, input logic [4:0] zt);
        return {11'b10100101111, rm, 3'b010, pg, rn, zt};
    endfunction

    // memory model: random ready, random response latency, address check (R3, R4)
    initial begin
        forever begin
            @(negedge clk);
            mresp_valid = 1'b0;
            if (pending == 0) begin
                mresp_valid = 1'b1;
                mresp_data  = mem_fn(held_addr);
                pending     = -1;
                mreq_ready  = 1'b0;
            end else if (pending > 0) begin
                pending--;
                mreq_ready = 1'b0;
            end else begin
                mreq_ready = ($urandom_range(0, 3) != 0);
                if (mreq_ready && mreq_valid && rst_n) begin
                    if (req_seen < exp_n) begin
                        chk("R3 address", VW'(mreq_addr), VW'(exp_addr[req_seen]));
                    end else begin
                        chk("R4 unexpected request", VW'(1), VW'(0));
                    end
                    req_seen++;
                    held_addr = mreq_addr;
                    pending   = $urandom_range(0, 2);
                end
            end
        end
    end

    // kind: 0 ok, 1 undef, 2 align
    task automatic run_op(input logic [31:0] insn, input string tag);
        logic [4:0]    rm = insn[20:16];
        logic [4:0]    rn = insn[9:5];
        logic [2:0]    pg = insn[12:10];
        logic [4:0]    zt = insn[4:0];
        logic [63:0]   base, idx;
        logic [VW-1:0] exp_vec = '0;
        int            kind;
        int            n = 0;
        int            waited = 0;
        if (insn[31:21] != 11'b10100101111 || insn[15:13] != 3'b010 || rm == 5'd31) kind = 1;
        else if (rn == 5'd31 && sp_data[3:0] != 4'd0) kind = 2;
        else kind = 0;
        base = (rn == 5'd31) ? sp_data : gpr[rn];
        idx  = gpr[rm];
        for (int e = 0; e < NE; e++) begin
            if (kind == 0 && preg[pg][8*e]) begin
                exp_addr[n] = base + ((idx + 64'(e)) << 3);
                exp_vec[64*e +: 64] = mem_fn(exp_addr[n]);
                n++;
            end
        end
        exp_n    = n;
        req_seen = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_insn  = insn;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R9 ready after accept ", tag}, VW'(in_ready), VW'(kind != 0));
        while (!(wb_valid || undef_o || align_err_o) && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        chk({"R8 outcome exclusive ", tag}, VW'({wb_valid, undef_o, align_err_o}),
            VW'(kind == 0 ? 3'b100 : (kind == 1 ? 3'b010 : 3'b001)));
        if (kind == 0) begin
            chk({"R8 wb_idx ", tag}, VW'(wb_idx), VW'(zt));
            chk({"R5 R4 wb_data ", tag}, wb_data, exp_vec);
            @(negedge clk);
            chk({"R8 single pulse ", tag}, VW'(wb_valid), VW'(0));
        end else begin
            repeat (3) @(negedge clk);
            chk({kind == 1 ? "R1 R2 no access " : "R7 no access ", tag},
                VW'(req_seen), VW'(0));
        end
        chk({"R3 request count ", tag}, VW'(req_seen), VW'(exp_n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED1234));
        for (int r = 0; r < 32; r++) gpr[r] = {$urandom(), $urandom()};
        for (int p = 0; p < 8; p++) preg[p] = PW'({$urandom(), $urandom()});
        exp_n = 0;
        req_seen = 0;
        repeat (4) @(negedge clk);
        chk("R9 reset in_ready", VW'(in_ready), VW'(1));
        chk("R8 reset wb_valid", VW'(wb_valid), VW'(0));
        chk("R3 reset mreq_valid", VW'(mreq_valid), VW'(0));
        rst_n = 1'b1;

        // R11: all lanes off
        preg[0] = '0;
        run_op(mk_insn(5'd2, 3'd0, 5'd1, 5'd7), "R11 all inactive");
        // R5: all lanes on
        preg[1] = '1;
        run_op(mk_insn(5'd3, 3'd1, 5'd4, 5'd9), "all active");
        // R4: alternate lanes, index still advances past off lanes
        preg[2] = PW'(32'h0001_0001);
        run_op(mk_insn(5'd5, 3'd2, 5'd6, 5'd11), "R4 alternate");
        preg[3] = PW'(32'h0100_0000);
        run_op(mk_insn(5'd5, 3'd3, 5'd6, 5'd12), "R4 last only");
        // R3: address wrap
        gpr[8] = 64'hFFFF_FFFF_FFFF_FFF0;
        gpr[9] = 64'h1FFF_FFFF_FFFF_FFFF;
        run_op(mk_insn(5'd9, 3'd1, 5'd8, 5'd0), "R3 wrap");
        // R6: stack pointer base, aligned
        sp_data = 64'h0000_7FFF_FFFF_FF00;
        run_op(mk_insn(5'd3, 3'd1, 5'd31, 5'd31), "R6 sp base");
        // R7: misaligned stack pointer; general register base unchecked
        sp_data = 64'h0000_7FFF_FFFF_FF08;
        run_op(mk_insn(5'd3, 3'd1, 5'd31, 5'd2), "R7 sp misaligned");
        gpr[10] = 64'h1003;
        run_op(mk_insn(5'd3, 3'd1, 5'd10, 5'd3), "R7 gpr base unaligned");
        // R2: index field 31
        run_op(mk_insn(5'd31, 3'd1, 5'd4, 5'd5), "R2 rm31");
        // R1: pattern mismatches
        run_op(mk_insn(5'd3, 3'd1, 5'd4, 5'd5) ^ 32'h8000_0000, "R1 bit31");
        run_op(mk_insn(5'd3, 3'd1, 5'd4, 5'd5) ^ 32'h0000_2000, "R1 bit13");

        // random mix
        for (int i = 0; i < 80; i++) begin
            logic [31:0] w;
            w = mk_insn(5'($urandom_range(0, 31)), 3'($urandom_range(0, 7)),
                        5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
            if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(13, 31));
            sp_data = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) != 0) sp_data[3:0] = 4'd0;
            if ($urandom_range(0, 3) == 0) preg[w[12:10]] = PW'({$urandom(), $urandom()});
            run_op(w, "random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule